// File: doc/BRIEF.md
# Nibble-Serial Register Access Decoder

This block terminates a byte-wide command stream from a host link and turns it into accesses to a small local register file. Every command byte is split into two fields. The upper four bits select an operation, and the lower four bits carry a payload nibble. An 8-bit register address is built from two address commands. Write data is built from a data-low nibble that is held until a data-high command supplies the upper nibble, and that second command performs the write.

Read commands return the addressed register as one byte on an output stream with a valid/ready handshake. One read variant steps the address forward after each byte, so a run of such commands can return a multi-byte field, least significant byte first, without the address being sent again. Writes also step the address, so several data pairs after one address fill consecutive registers. While a returned byte waits for the host, the decoder takes no further commands, unless the host takes that byte in the same cycle.

Top module: `nsr_decoder`

## Requirements
- R1: While rst_n is low and after it is released, rd_valid is 0, cmd_ready is 1, the address and the held data-low nibble are 0, and every register reads back as 0x00.
- R2: Opcode (bits 7:4) 0x0 loads address bits 3:0 and 0x1 loads address bits 7:4, each from the command's bits 3:0. The other half of the address is left unchanged.
- R3: Opcode 0x2 stores bits 3:0 as the held data-low nibble. Opcode 0x3 writes {its bits 3:0, held nibble} into register (address mod 16) in the cycle it is accepted, and then advances the address by one.
- R4: Several data-low/data-high pairs after one address write consecutive registers.
- R5: Opcode 0x4 returns the contents of register (address mod 16) on rd_data with rd_valid high in the cycle after acceptance, and leaves the address unchanged.
- R6: Opcode 0x5 (the read with bit 4 set as the next-register flag) returns the current register like R5 and then advances the address by one. Consecutive such commands return consecutive registers in rising order.
- R7: The address is 8 bits wide and wraps from 0xFF to 0x00. Only address bits 3:0 select one of the 16 registers.
- R8: Opcodes 0x6 to 0xF are accepted and ignored. They change neither the address, the held nibble nor any register.
- R9: While rd_valid is 1 and rd_ready is 0, rd_data stays stable, rd_valid stays 1 and cmd_ready is 0, so no command is taken.
- R10: When rd_valid and rd_ready are both 1, cmd_ready is 1. A read accepted in that cycle replaces the byte with no idle cycle between the two.
- R11: The held data-low nibble is kept after a write. A data-high command with no new data-low command reuses it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | A command byte is offered |
| cmd_data | input | 8 | Command byte: opcode in 7:4, payload nibble in 3:0 |
| cmd_ready | output | 1 | The decoder accepts the offered command this cycle |
| rd_valid | output | 1 | A read-back byte is waiting |
| rd_data | output | 8 | Read-back byte |
| rd_ready | input | 1 | The host takes the read-back byte this cycle |

## Verification
Two functions can fall in the same cycle: the host draining a waiting read byte and the decoder accepting the next read command. This happens when rd_ready is held high while a stream of next-register reads is kept on the command port. The bench then expects a new byte on every cycle, in register order, with rd_valid never dropping in between. The opposite case is a data-high-write offered while a byte waits and rd_ready is low. The bench judges it by reading that register back afterwards and checking that it is unchanged.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

  typedef enum logic [3:0] {
    OP_ADDR_LO   = 4'h0,
    OP_ADDR_HI   = 4'h1,
    OP_DATA_LO   = 4'h2,
    OP_DATA_WR   = 4'h3,
    OP_READ      = 4'h4,
    OP_READ_NEXT = 4'h5
  } nsr_op_e;

  typedef struct packed {
    logic addr_lo;
    logic addr_hi;
    logic data_lo;
    logic wr;
    logic rd;
    logic rd_next;
  } nsr_strb_t;

endpackage

// File: rtl/nsr_cmd_parse.sv
module nsr_cmd_parse
  import nsr_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               cmd_fire,
  input  logic [2*NIB_W-1:0] cmd_data,
  output nsr_strb_t          strb,
  output logic [NIB_W-1:0]   nib
);

  logic [NIB_W-1:0] op_field;

  assign op_field = cmd_data[2*NIB_W-1:NIB_W];
  assign nib      = cmd_data[NIB_W-1:0];

  always_comb begin
    strb = '0;
    if (cmd_fire) begin
      case (op_field)
        NIB_W'(OP_ADDR_LO):   strb.addr_lo = 1'b1;
        NIB_W'(OP_ADDR_HI):   strb.addr_hi = 1'b1;
        NIB_W'(OP_DATA_LO):   strb.data_lo = 1'b1;
        NIB_W'(OP_DATA_WR):   strb.wr      = 1'b1;
        NIB_W'(OP_READ):      strb.rd      = 1'b1;
        NIB_W'(OP_READ_NEXT): strb.rd_next = 1'b1;
        default:              strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/nsr_addr_data.sv
module nsr_addr_data
  import nsr_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_fire,
  input  nsr_strb_t          strb,
  input  logic [NIB_W-1:0]   nib,
  output logic [2*NIB_W-1:0] addr_q,
  output logic [2*NIB_W-1:0] wdata
);

  localparam int ADDR_W = 2 * NIB_W;

  logic [NIB_W-1:0]  lo_q, lo_d;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en, lo_en;

  assign wdata = {nib, lo_q};

  always_comb begin
    addr_d  = addr_q;
    addr_en = 1'b0;
    if (strb.addr_lo) begin
      addr_d  = {addr_q[ADDR_W-1:NIB_W], nib};
      addr_en = 1'b1;
    end else if (strb.addr_hi) begin
      addr_d  = {nib, addr_q[NIB_W-1:0]};
      addr_en = 1'b1;
    end else if (strb.wr || strb.rd_next) begin
      addr_d  = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
      addr_en = 1'b1;
    end
    lo_en = strb.data_lo;
    lo_d  = nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (lo_en)   lo_q   <= lo_d;
    end
  end

  assert_ignored_stable_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && (strb == '0)) |=> ($stable(addr_q) && $stable(lo_q)));

  assert_read_next_step_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    strb.rd_next |=> (addr_q == $past(addr_q) + {{(ADDR_W-1){1'b0}}, 1'b1}));

  assert_plain_read_keeps_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    strb.rd |=> $stable(addr_q));

endmodule

// File: rtl/nsr_regfile.sv
module nsr_regfile #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data
);

  logic [DEPTH*DATA_W-1:0] mem_flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic              ent_en;
    logic [DATA_W-1:0] ent_q;
    assign ent_en = wr_en && (wr_idx == g[$clog2(DEPTH)-1:0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= wr_data;
    end
    assign mem_flat[g*DATA_W +: DATA_W] = ent_q;
  end

  assign rd_data = mem_flat[rd_idx*DATA_W +: DATA_W];

  assert_no_write_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_flat));

endmodule

// File: rtl/nsr_rdout.sv
module nsr_rdout #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              take_ok
);

  logic              valid_d;
  logic [DATA_W-1:0] data_d;
  logic              data_en;

  assign take_ok = !rd_valid || rd_ready;

  always_comb begin
    valid_d = rd_valid;
    data_en = 1'b0;
    data_d  = load_data;
    if (load) begin
      valid_d = 1'b1;
      data_en = 1'b1;
    end else if (rd_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= valid_d;
      if (data_en) rd_data <= data_d;
    end
  end

  assert_stall_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_load_shows_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rd_valid);

  assert_no_bubble_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && load) |=> rd_valid);

endmodule

// File: rtl/nsr_decoder.sv
module nsr_decoder
  import nsr_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int REG_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2*NIB_W-1:0] cmd_data,
  output logic               cmd_ready,
  output logic               rd_valid,
  output logic [2*NIB_W-1:0] rd_data,
  input  logic               rd_ready
);

  localparam int BYTE_W = 2 * NIB_W;
  localparam int IDX_W  = $clog2(REG_DEPTH);

  logic              cmd_fire;
  nsr_strb_t         strb;
  logic [NIB_W-1:0]  nib;
  logic [BYTE_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata;
  logic [BYTE_W-1:0] reg_rd;

  assign cmd_fire = cmd_valid && cmd_ready;

  nsr_cmd_parse #(.NIB_W(NIB_W)) u_parse (
    .cmd_fire (cmd_fire),
    .cmd_data (cmd_data),
    .strb     (strb),
    .nib      (nib)
  );

  nsr_addr_data #(.NIB_W(NIB_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_fire (cmd_fire),
    .strb     (strb),
    .nib      (nib),
    .addr_q   (addr_q),
    .wdata    (wdata)
  );

  nsr_regfile #(.DEPTH(REG_DEPTH), .DATA_W(BYTE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (strb.wr),
    .wr_idx  (addr_q[IDX_W-1:0]),
    .wr_data (wdata),
    .rd_idx  (addr_q[IDX_W-1:0]),
    .rd_data (reg_rd)
  );

  nsr_rdout #(.DATA_W(BYTE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (strb.rd || strb.rd_next),
    .load_data (reg_rd),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .take_ok   (cmd_ready)
  );

  assert_stall_blocks_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |-> !cmd_ready);

endmodule

// File: tb/nsr_decoder_bench.sv
module nsr_decoder_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_data;
  logic       cmd_ready;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_ready;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nsr_decoder u_nsr_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .cmd_ready (cmd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_ready  (rd_ready)
  );

  // {check, command, expected byte}; checked entries are reads
  localparam int NV = 18;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h02, 8'h00},  // R2 address low = 2
    {1'b0, 8'h10, 8'h00},  // R2 address high = 0
    {1'b0, 8'h2A, 8'h00},  // R3 data low A
    {1'b0, 8'h35, 8'h00},  // R3 write 0x5A to reg 2
    {1'b0, 8'h2C, 8'h00},  // R4 second pair
    {1'b0, 8'h3B, 8'h00},  // R4 write 0xBC to reg 3
    {1'b0, 8'h21, 8'h00},
    {1'b0, 8'h30, 8'h00},  // R4 write 0x01 to reg 4
    {1'b0, 8'h02, 8'h00},
    {1'b0, 8'h10, 8'h00},
    {1'b1, 8'h40, 8'h5A},  // R5 plain read
    {1'b1, 8'h40, 8'h5A},  // R5 address unchanged
    {1'b1, 8'h50, 8'h5A},  // R6 read next
    {1'b1, 8'h50, 8'hBC},
    {1'b1, 8'h50, 8'h01},
    {1'b1, 8'h50, 8'h00},  // R6 reg 5 untouched
    {1'b0, 8'h04, 8'h00},
    {1'b1, 8'h40, 8'h01}   // R6 low nibble reload to reg 4
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] cmd, input logic [7:0] exp, input string tag);
    send(cmd);
    chk(tag, {7'd0, rd_valid}, 8'h01);
    chk(tag, rd_data, exp);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = 8'h00; rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rd_valid in reset", {7'd0, rd_valid}, 8'h00);
    chk("R1 cmd_ready in reset", {7'd0, cmd_ready}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) rd_chk(VEC[i][15:8], VEC[i][7:0], $sformatf("R5/R6 table %0d", i));
      else            send(VEC[i][15:8]);
    end

    // R10: drain and next read in the same cycle
    send(8'h02); send(8'h10);
    @(negedge clk);
    rd_ready = 1'b1; cmd_valid = 1'b1; cmd_data = 8'h50;
    @(negedge clk);
    chk("R10 stream 0 valid", {7'd0, rd_valid}, 8'h01);
    chk("R10 stream 0 data", rd_data, 8'h5A);
    @(negedge clk);
    chk("R10 stream 1 valid", {7'd0, rd_valid}, 8'h01);
    chk("R10 stream 1 data", rd_data, 8'hBC);
    @(negedge clk);
    chk("R10 stream 2 valid", {7'd0, rd_valid}, 8'h01);
    chk("R10 stream 2 data", rd_data, 8'h01);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R10 drained", {7'd0, rd_valid}, 8'h00);
    rd_ready = 1'b0;

    // R9: stall holds byte and blocks a pending write
    send(8'h03); send(8'h10);
    send(8'h40);
    cmd_valid = 1'b1; cmd_data = 8'h3F;
    for (int k = 0; k < 3; k++) begin
      chk("R9 valid held", {7'd0, rd_valid}, 8'h01);
      chk("R9 data held", rd_data, 8'hBC);
      chk("R9 cmd_ready low", {7'd0, cmd_ready}, 8'h00);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    rd_chk(8'h40, 8'hBC, "R9 stalled write not taken");

    // R8 / R11: ignored opcodes, held nibble
    send(8'h22); send(8'h8F); send(8'h6A); send(8'hF5);
    send(8'h3E);
    send(8'h03); send(8'h10);
    rd_chk(8'h40, 8'hE2, "R8 ignored opcodes");
    send(8'h04);
    send(8'h37);
    send(8'h04);
    rd_chk(8'h40, 8'h72, "R11 nibble reused");

    // R7: wrap and index by low bits
    send(8'h0F); send(8'h1F);
    send(8'h2E); send(8'h3D);
    send(8'h0F); send(8'h1F);
    rd_chk(8'h50, 8'hDE, "R7 reg 15");
    rd_chk(8'h50, 8'h00, "R7 wrap to reg 0");
    send(8'h03); send(8'h1A);
    rd_chk(8'h40, 8'hE2, "R7 high bits ignored for index");

    // R1: reset clears registers, address, nibble
    send(8'h00); send(8'h10); send(8'h29); send(8'h39);
    send(8'h00);
    rd_chk(8'h40, 8'h99, "R1 pre-reset write");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rd_valid after reset", {7'd0, rd_valid}, 8'h00);
    chk("R1 cmd_ready after reset", {7'd0, cmd_ready}, 8'h01);
    rst_n = 1'b1;
    rd_chk(8'h40, 8'h00, "R1 reg 0 and address cleared");
    send(8'h02); send(8'h10);
    rd_chk(8'h40, 8'h00, "R1 reg 2 cleared");
    send(8'h35);
    send(8'h02); send(8'h10);
    rd_chk(8'h40, 8'h50, "R1 nibble cleared");

    report();
  end

endmodule